// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a single-word load or store and, in the same step, the value the base register should take afterwards. A five-bit mode key tells it three things. The first is whether the offset is a zero-extended 12-bit immediate or a shifted register index. The second is whether the address is taken before or after the offset is applied. The third is whether the offset is added or subtracted, and whether the offset base is written back. The base value, the immediate, the index register value and its shift controls come from the decode and register-read stages. The register file write and the memory access happen elsewhere.

The result is captured in one output register stage when the capture enable is high, and held when it is low. The index path follows the same immediate-shift conventions as the data-processing shifter. Key codes that no load or store form uses raise an error flag, and writeback is suppressed for them.

Top module: `lsag_top`

## Requirements
- R1: While reset is asserted, and until the first capture after reset, addr_out, base_new, wb_en and key_err are all zero.
- R2: Key bit 4 clear selects imm_ofs zero-extended to 32 bits as the offset. Key bit 4 set selects the shifted register index.
- R3: Key bit 3 set (pre-index) gives addr_out = base ± offset. Key bit 3 clear (post-index) gives addr_out = base_val unchanged.
- R4: Key bit 2 set adds the offset and key bit 2 clear subtracts it. This holds for every mode, and post-index register keys 20 and 21 add.
- R5: Post-index keys (0, 1, 4, 5, 16, 17, 20, 21) always set wb_en, whatever key bit 0 is. Pre-index keys set wb_en only when key bit 0 is 1 (9, 13, 25, 29). Keys 8, 12, 24 and 28 clear it. When wb_en is 1, base_new = base ± offset. Otherwise base_new = base_val.
- R6: Any key with bit 1 set sets key_err, clears wb_en, and gives addr_out = base_new = base_val.
- R7: shf_kind 0 is a logical left shift by shf_amt. shf_kind 1 is a logical right shift, where an amount of 0 means 32 and gives zero.
- R8: shf_kind 2 is an arithmetic right shift, where an amount of 0 means 32 and gives 32 copies of bit 31.
- R9: shf_kind 3 is a rotate right by shf_amt. An amount of 0 instead gives {carry_in, rm_val[31:1]}.
- R10: All outputs change only at a rising clock edge where cap_en is 1, one edge after the inputs are presented. With cap_en 0 they hold.
- R11: Sums and differences wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_en | input | 1 | Capture enable for the output stage |
| mode_key | input | 5 | {use_reg, pre, up, bit1 (must be 0), wb_req} |
| base_val | input | 32 | Base register value |
| imm_ofs | input | 12 | Immediate offset |
| rm_val | input | 32 | Index register value |
| shf_kind | input | 2 | Index shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR/RRX) |
| shf_amt | input | 5 | Index shift amount |
| carry_in | input | 1 | Carry flag used by RRX |
| addr_out | output | 32 | Effective address |
| base_new | output | 32 | Value for base writeback |
| wb_en | output | 1 | Base writeback enable |
| key_err | output | 1 | Unused key code |

## Verification
Every legal key is driven with a base and an offset chosen so that base, base+offset and base−offset all differ. A single sample therefore shows whether the address is pre- or post-index, which direction was taken, and whether writeback happened. The register-index keys are run with all four shift kinds, each at amount zero and at a non-zero amount, so that the 32-bit and RRX special cases stand apart from ordinary shifts. Keys with bit 1 set are mixed among the legal ones, operands near zero and near 2^32 exercise wraparound, and a cycle with cap_en low and changed inputs shows that the outputs hold.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } lsag_shk_t;

  typedef struct packed {
    logic use_reg;
    logic pre;
    logic up;
    logic wb;
    logic err;
  } lsag_ctl_t;

endpackage

// File: rtl/lsag_key_decode.sv
module lsag_key_decode
  import lsag_pkg::*;
#(
  parameter int KEY_W = 5
) (
  input  logic [KEY_W-1:0] key,
  output lsag_ctl_t        ctl
);

  localparam int B_REG = 4;
  localparam int B_PRE = 3;
  localparam int B_UP  = 2;
  localparam int B_BAD = 1;
  localparam int B_WB  = 0;

  logic legal;

  always_comb begin
    legal       = ~key[B_BAD];
    ctl.use_reg = key[B_REG];
    ctl.pre     = key[B_PRE];
    ctl.up      = key[B_UP];
    ctl.err     = ~legal;
    // post-index always writes back; pre-index only on request
    ctl.wb      = legal & (~key[B_PRE] | key[B_WB]);
  end

endmodule

// File: rtl/lsag_index_shift.sv
module lsag_index_shift
  import lsag_pkg::*;
#(
  parameter int DW   = 32,
  parameter int SA_W = 5
) (
  input  logic [DW-1:0]   rm,
  input  logic [1:0]      kind,
  input  logic [SA_W-1:0] amt,
  input  logic            cin,
  output logic [DW-1:0]   idx
);

  logic [2*DW-1:0] dbl;
  logic            zero_amt;
  logic [DW-1:0]   asr_v;

  always_comb begin
    dbl      = {rm, rm} >> amt;
    zero_amt = (amt == '0);
    asr_v    = DW'($signed(rm) >>> amt);
    unique case (lsag_shk_t'(kind))
      SH_LSL: idx = rm << amt;
      SH_LSR: idx = zero_amt ? '0 : (rm >> amt);
      SH_ASR: idx = zero_amt ? {DW{rm[DW-1]}} : asr_v;
      SH_ROR: idx = zero_amt ? {cin, rm[DW-1:1]} : dbl[DW-1:0];
      default: idx = rm;
    endcase
  end

endmodule

// File: rtl/lsag_offset_add.sv
module lsag_offset_add #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] ofs,
  input  logic          up,
  output logic [DW-1:0] res
);

  always_comb begin
    res = up ? (base + ofs) : (base - ofs);
  end

endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFS_W = 12,
  parameter int SA_W  = 5,
  parameter int KEY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [KEY_W-1:0] mode_key,
  input  logic [DW-1:0]    base_val,
  input  logic [OFS_W-1:0] imm_ofs,
  input  logic [DW-1:0]    rm_val,
  input  logic [1:0]       shf_kind,
  input  logic [SA_W-1:0]  shf_amt,
  input  logic             carry_in,
  output logic [DW-1:0]    addr_out,
  output logic [DW-1:0]    base_new,
  output logic             wb_en,
  output logic             key_err
);

  localparam int PAD_W = DW - OFS_W;

  // reset synchronizer: asserts at once, releases on clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  lsag_ctl_t     ctl;
  logic [DW-1:0] idx_v;
  logic [DW-1:0] ofs_v;
  logic [DW-1:0] moved;

  lsag_key_decode #(.KEY_W(KEY_W)) u_dec (
    .key (mode_key),
    .ctl (ctl)
  );

  lsag_index_shift #(.DW(DW), .SA_W(SA_W)) u_shf (
    .rm   (rm_val),
    .kind (shf_kind),
    .amt  (shf_amt),
    .cin  (carry_in),
    .idx  (idx_v)
  );

  assign ofs_v = ctl.use_reg ? idx_v : {{PAD_W{1'b0}}, imm_ofs};

  lsag_offset_add #(.DW(DW)) u_add (
    .base (base_val),
    .ofs  (ofs_v),
    .up   (ctl.up),
    .res  (moved)
  );

  logic [DW-1:0] addr_d, bnew_d;
  logic          wb_d, err_d;
  logic [DW-1:0] addr_q, bnew_q;
  logic          wb_q, err_q;

  // next-state
  always_comb begin
    addr_d = addr_q;
    bnew_d = bnew_q;
    wb_d   = wb_q;
    err_d  = err_q;
    if (cap_en) begin
      addr_d = (ctl.pre && !ctl.err) ? moved : base_val;
      bnew_d = ctl.wb ? moved : base_val;
      wb_d   = ctl.wb;
      err_d  = ctl.err;
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      addr_q <= '0;
      bnew_q <= '0;
      wb_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      bnew_q <= bnew_d;
      wb_q   <= wb_d;
      err_q  <= err_d;
    end
  end

  assign addr_out = addr_q;
  assign base_new = bnew_q;
  assign wb_en    = wb_q;
  assign key_err  = err_q;

  // R6
  a_r6_bad_key_no_wb: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cap_en && mode_key[1]) |=> (key_err && !wb_en && addr_out == $past(base_val)));

  // R3
  a_r3_post_uses_base: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cap_en && !mode_key[3] && !mode_key[1]) |=> (addr_out == $past(base_val)));

  // R5
  a_r5_post_writes_back: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cap_en && !mode_key[3] && !mode_key[1]) |=> wb_en);

  // R5
  a_r5_pre_no_wb_req: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cap_en && mode_key[3] && !mode_key[0]) |=> (!wb_en && base_new == $past(base_val)));

  // R5
  a_r5_pre_wb_matches_addr: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cap_en && mode_key[3] && !mode_key[1] && mode_key[0]) |=> (wb_en && base_new == addr_out));

  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    !cap_en |=> ($stable(addr_out) && $stable(base_new) && $stable(wb_en) && $stable(key_err)));

endmodule

// File: tb/sim_lsag_top.sv
module sim_lsag_top;

  logic        clk;
  logic        rst_n;
  logic        cap_en;
  logic [4:0]  mode_key;
  logic [31:0] base_val;
  logic [11:0] imm_ofs;
  logic [31:0] rm_val;
  logic [1:0]  shf_kind;
  logic [4:0]  shf_amt;
  logic        carry_in;
  logic [31:0] addr_out;
  logic [31:0] base_new;
  logic        wb_en;
  logic        key_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  lsag_top u0 (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mode_key(mode_key),
    .base_val(base_val), .imm_ofs(imm_ofs), .rm_val(rm_val),
    .shf_kind(shf_kind), .shf_amt(shf_amt), .carry_in(carry_in),
    .addr_out(addr_out), .base_new(base_new), .wb_en(wb_en), .key_err(key_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  // index per R7-R9, rotation built bit by bit
  function automatic logic [31:0] ref_idx(logic [31:0] rm, logic [1:0] k, logic [4:0] a, logic c);
    logic [31:0] v;
    v = rm;
    case (k)
      2'd0: v = rm << a;
      2'd1: v = (a == 0) ? 32'h0 : rm >> a;
      2'd2: begin
        if (a == 0) v = {32{rm[31]}};
        else for (int i = 0; i < int'(a); i++) v = {v[31], v[31:1]};
      end
      default: begin
        if (a == 0) v = {c, rm[31:1]};
        else for (int i = 0; i < int'(a); i++) v = {v[0], v[31:1]};
      end
    endcase
    return v;
  endfunction

  task automatic run(input string req, input logic [4:0] key, input logic [31:0] b,
                     input logic [11:0] im, input logic [31:0] rm, input logic [1:0] k,
                     input logic [4:0] a, input logic c);
    logic [31:0] ofs, mv, ea, bn;
    logic        wb, er;
    @(negedge clk);
    cap_en = 1'b1; mode_key = key; base_val = b; imm_ofs = im;
    rm_val = rm; shf_kind = k; shf_amt = a; carry_in = c;
    ofs = key[4] ? ref_idx(rm, k, a, c) : {20'h0, im};
    mv  = key[2] ? b + ofs : b - ofs;
    er  = key[1];
    wb  = !er && (!key[3] || key[0]);
    ea  = (key[3] && !er) ? mv : b;
    bn  = wb ? mv : b;
    @(negedge clk);
    cap_en = 1'b0;
    chk({req, " addr"}, addr_out, ea);
    chk({req, " base_new"}, base_new, bn);
    chk({req, " wb_en"}, {31'h0, wb_en}, {31'h0, wb});
    chk({req, " key_err"}, {31'h0, key_err}, {31'h0, er});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cap_en = 1'b0; mode_key = 5'd0; base_val = 32'h0;
    imm_ofs = 12'h0; rm_val = 32'h0; shf_kind = 2'd0; shf_amt = 5'd0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 addr reset", addr_out, 32'h0);
    chk("R1 base_new reset", base_new, 32'h0);
    chk("R1 wb reset", {31'h0, wb_en}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 err after release", {31'h0, key_err}, 32'h0);
  endtask

  task automatic t_imm_modes();
    for (int key = 0; key < 16; key++)
      if (key[1] == 1'b0) run("R2 R3 R4 R5 imm", 5'(key), 32'h0000_1000, 12'h234, 32'hFFFF_FFFF, 2'd0, 5'd0, 1'b0);
  endtask

  task automatic t_reg_modes();
    for (int key = 16; key < 32; key++)
      if (key[1] == 1'b0) run("R2 R3 R4 R5 reg", 5'(key), 32'h0004_0000, 12'h7FF, 32'h0000_0010, 2'd0, 5'd2, 1'b0);
    run("R4 post reg add key20", 5'd20, 32'h100, 12'h0, 32'h8, 2'd0, 5'd0, 1'b0);
    run("R4 post reg add key21", 5'd21, 32'h100, 12'h0, 32'h8, 2'd0, 5'd1, 1'b0);
  endtask

  task automatic t_shifts();
    run("R7 lsl",     5'd28, 32'h1000, 12'h0, 32'h0000_0003, 2'd0, 5'd4, 1'b0);
    run("R7 lsr",     5'd28, 32'h1000, 12'h0, 32'h8000_0000, 2'd1, 5'd20, 1'b0);
    run("R7 lsr32",   5'd28, 32'h1000, 12'h0, 32'hFFFF_FFFF, 2'd1, 5'd0, 1'b0);
    run("R8 asr",     5'd24, 32'h1000, 12'h0, 32'h8000_0000, 2'd2, 5'd28, 1'b0);
    run("R8 asr32 neg", 5'd28, 32'h1000, 12'h0, 32'h8000_0001, 2'd2, 5'd0, 1'b0);
    run("R8 asr32 pos", 5'd28, 32'h1000, 12'h0, 32'h7000_0001, 2'd2, 5'd0, 1'b0);
    run("R9 ror",     5'd28, 32'h0, 12'h0, 32'h0000_00F1, 2'd3, 5'd4, 1'b0);
    run("R9 rrx c1",  5'd28, 32'h0, 12'h0, 32'h0000_0006, 2'd3, 5'd0, 1'b1);
    run("R9 rrx c0",  5'd29, 32'h0, 12'h0, 32'h0000_0007, 2'd3, 5'd0, 1'b0);
  endtask

  task automatic t_bad_keys();
    run("R6 key2",  5'd2,  32'hABCD_0000, 12'h10, 32'h1, 2'd0, 5'd0, 1'b0);
    run("R6 key3",  5'd3,  32'hABCD_0004, 12'h10, 32'h1, 2'd0, 5'd0, 1'b0);
    run("R6 key15", 5'd15, 32'hABCD_0008, 12'h10, 32'h1, 2'd0, 5'd0, 1'b0);
    run("R6 key31", 5'd31, 32'hABCD_000C, 12'h10, 32'h1, 2'd0, 5'd0, 1'b0);
  endtask

  task automatic t_wrap();
    run("R11 add wrap", 5'd13, 32'hFFFF_FFF0, 12'h020, 32'h0, 2'd0, 5'd0, 1'b0);
    run("R11 sub wrap", 5'd9,  32'h0000_0004, 12'h008, 32'h0, 2'd0, 5'd0, 1'b0);
  endtask

  task automatic t_hold();
    run("R10 setup", 5'd13, 32'h2000, 12'h040, 32'h0, 2'd0, 5'd0, 1'b0);
    @(negedge clk);
    cap_en = 1'b0; mode_key = 5'd8; base_val = 32'h5555_0000; imm_ofs = 12'h111;
    repeat (2) @(negedge clk);
    chk("R10 hold addr", addr_out, 32'h2040);
    chk("R10 hold base_new", base_new, 32'h2040);
    chk("R10 hold wb", {31'h0, wb_en}, 32'h1);
  endtask

  initial begin
    t_reset();
    t_imm_modes();
    t_reg_modes();
    t_shifts();
    t_bad_keys();
    t_wrap();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule